// File: doc/BRIEF.md
# Software-Loaded Address Translator with Real-Mode Fallback

This block turns an effective address into a physical address plus three access attributes (cache inhibit, write-through, guarded). It reports whether translation happened, whether no entry matched, and whether the access broke the matching page's permissions. Translation uses a small fully associative table that software fills one entry at a time. Each entry takes two separate writes to the same slot: one for the tag word and one for the data word. The table has no walker. A miss is simply reported.

Two mode bits decide which path each access takes. The fetch-translate bit governs instruction fetches and the data-translate bit governs loads and stores. With its bit clear, an access runs in real mode: the address passes through unchanged and cacheability comes from one of two 32-bit region registers, one for fetches and one for data. Each register bit covers one 128 MB region. Taking an exception clears both mode bits at once, so the accesses that follow use the real-mode attributes until software sets the bits again.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel one register stage later. A request is accepted only when the output stage is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result holds steady and `req_ready` stays low. This is the only back-pressure. The table-write, region-register, mode and exception pins are plain one-cycle strobes.

Top module: `xlat_unit`

## Requirements
- R1: A table entry is loaded by two writes at the same index, selected by `tlb_word` (0 = tag, 1 = data). Tag word (bit 31 = MSB): page number in [31:10], size code in [9:7], valid in [6], endian in [5], user bit in [4]. Data word: real page number in [31:10], execute-allowed in [9], write-allowed in [8], zone in [7:4], write-through in [3], cache-inhibit in [2], coherent in [1], guarded in [0].
- R2: A valid entry with size code S covers 1 KB × 4^S. It matches when the address bits above bit 10+2S equal the same tag bits. The physical address takes the real page number above that bit and the effective address below it.
- R3: Access kind codes are 0 = fetch, 1 = load, 2 = store, with 3 treated as a load. A fetch is translated only when `ir_on` = 1, and a load or store only when `dr_on` = 1. Otherwise the access is in real mode: `rsp_paddr` equals the address, `rsp_xlated` = 0, and neither fault flag is set.
- R4: In real mode, region r = addr[31:27] is cacheable when bit (31−r) of the fetch region register (for fetches) or the data region register (for loads and stores) is 1. `rm_sel` = 0 writes the fetch register and 1 writes the data register. Cache inhibit is the inverse of that bit, and write-through and guarded are 0. Both registers reset to 0.
- R5: `exc_take` clears both mode bits on the next edge and overrides a mode write in the same cycle. Both bits reset to 0.
- R6: A translated access that matches no valid entry sets `rsp_miss` and returns physical address 0 with all attributes 0.
- R7: A translated store to a page with write-allowed = 0, or a translated fetch from a page with execute-allowed = 0, sets `rsp_perm_fault` and returns address 0 with all attributes 0. Loads never raise it.
- R8: When more than one valid entry matches, the lowest index supplies the result.
- R9: `tlb_inv_all` clears every valid bit in one cycle. A tag write in the same cycle still stores its word, but the entry stays invalid.
- R10: The result of a request accepted at one edge appears at the next edge. `req_ready` = !rsp_valid || rsp_ready. A stalled result stays stable.
- R11: A translated hit with permission sets `rsp_xlated` and takes write-through, cache-inhibit and guarded from data bits [3], [2] and [0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_addr | input | 32 | Effective address |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_inhibit | output | 1 | Cache inhibit |
| rsp_wthru | output | 1 | Write-through |
| rsp_guard | output | 1 | Guarded |
| rsp_xlated | output | 1 | Access went through the table |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_perm_fault | output | 1 | Execute or write not allowed |
| tlb_we | input | 1 | Table word write strobe |
| tlb_idx | input | IDX_W | Entry index |
| tlb_word | input | 1 | 0 tag, 1 data |
| tlb_wdata | input | 32 | Word written |
| tlb_inv_all | input | 1 | Clear all valid bits |
| rm_we | input | 1 | Region register write strobe |
| rm_sel | input | 1 | 0 fetch register, 1 data register |
| rm_wdata | input | 32 | Region register value |
| mode_we | input | 1 | Mode bit write strobe |
| mode_ir | input | 1 | New fetch-translate bit |
| mode_dr | input | 1 | New data-translate bit |
| exc_take | input | 1 | Exception entry, clears both mode bits |
| ir_on | output | 1 | Fetch-translate bit |
| dr_on | output | 1 | Data-translate bit |

## Verification
A corrupted tag, size code or valid bit shows up on the next request to the affected page as a wrong `rsp_miss` or `rsp_paddr`, one cycle after acceptance. A fault in the priority pick shows only on addresses covered by two entries, so such an overlap is set up on purpose and later broken by clearing the lower entry. Wrong region or mode state shows as a flipped `rsp_inhibit` or `rsp_xlated`, and every one of the 32 regions is swept under both region registers. A stall fault shows as a result that changes while `rsp_ready` is low, or as a request that is taken while `req_ready` should be 0.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int AW = 32;
  localparam int OFF_BASE = 10;

  // tag word field positions
  localparam int T_SZ_HI = 9;
  localparam int T_SZ_LO = 7;
  localparam int T_VLD   = 6;
  // data word field positions
  localparam int D_EX = 9;
  localparam int D_WR = 8;
  localparam int D_WT = 3;
  localparam int D_CI = 2;
  localparam int D_GD = 0;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2,
    K_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic          xl;
    logic          miss;
    logic          perm;
    logic          ci;
    logic          wt;
    logic          gd;
    logic [AW-1:0] pa;
  } xl_rsp_t;

  // ones below the page boundary for a size code
  function automatic logic [AW-1:0] off_mask(input logic [2:0] sz);
    logic [AW-1:0] one;
    one = {{(AW-1){1'b0}}, 1'b1};
    return (one << (OFF_BASE + 2 * int'(sz))) - one;
  endfunction
endpackage

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             widx,
  input  logic                         wsel,
  input  logic [31:0]                  wdata,
  input  logic                         inv_all,
  output logic [ENTRIES-1:0][31:0]     tag_q,
  output logic [ENTRIES-1:0][31:0]     data_q,
  output logic [ENTRIES-1:0]           valid_q
);
  import xlat_pkg::*;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic hit_w;
    assign hit_w = we && (int'(widx) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else begin
        if (hit_w && !wsel) tag_q[g]  <= wdata;
        if (hit_w &&  wsel) data_q[g] <= wdata;
        if (inv_all)
          valid_q[g] <= 1'b0;
        else if (hit_w && !wsel)
          valid_q[g] <= wdata[T_VLD];
      end
    end
  end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 4
) (
  input  logic [31:0]              addr,
  input  logic [ENTRIES-1:0][31:0] tag_q,
  input  logic [ENTRIES-1:0][31:0] data_q,
  input  logic [ENTRIES-1:0]       valid_q,
  output logic                     hit,
  output logic [31:0]              hit_tag,
  output logic [31:0]              hit_data
);
  import xlat_pkg::*;

  logic [ENTRIES-1:0] m;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [31:0] keep;
    assign keep = ~off_mask(tag_q[g][T_SZ_HI:T_SZ_LO]);
    assign m[g] = valid_q[g] && ((addr & keep) == (tag_q[g] & keep));
  end

  // scan from the top so the lowest matching index is applied last
  always_comb begin
    hit      = 1'b0;
    hit_tag  = '0;
    hit_data = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m[i]) begin
        hit      = 1'b1;
        hit_tag  = tag_q[i];
        hit_data = data_q[i];
      end
    end
  end
endmodule

// File: rtl/xlat_realmode.sv
module xlat_realmode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rm_we,
  input  logic        rm_sel,
  input  logic [31:0] rm_wdata,
  input  logic        mode_we,
  input  logic        mode_ir,
  input  logic        mode_dr,
  input  logic        exc_take,
  output logic        ir_on,
  output logic        dr_on,
  output logic [31:0] icc_q,
  output logic [31:0] dcc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icc_q <= '0;
      dcc_q <= '0;
    end else if (rm_we) begin
      if (rm_sel) dcc_q <= rm_wdata;
      else        icc_q <= rm_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_on <= 1'b0;
      dr_on <= 1'b0;
    end else if (exc_take) begin
      ir_on <= 1'b0;
      dr_on <= 1'b0;
    end else if (mode_we) begin
      ir_on <= mode_ir;
      dr_on <= mode_dr;
    end
  end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [31:0]      req_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_paddr,
  output logic             rsp_inhibit,
  output logic             rsp_wthru,
  output logic             rsp_guard,
  output logic             rsp_xlated,
  output logic             rsp_miss,
  output logic             rsp_perm_fault,
  input  logic             tlb_we,
  input  logic [IDX_W-1:0] tlb_idx,
  input  logic             tlb_word,
  input  logic [31:0]      tlb_wdata,
  input  logic             tlb_inv_all,
  input  logic             rm_we,
  input  logic             rm_sel,
  input  logic [31:0]      rm_wdata,
  input  logic             mode_we,
  input  logic             mode_ir,
  input  logic             mode_dr,
  input  logic             exc_take,
  output logic             ir_on,
  output logic             dr_on
);
  import xlat_pkg::*;

  logic [ENTRIES-1:0][31:0] tag_q, data_q;
  logic [ENTRIES-1:0]       valid_q;
  logic [31:0]              icc_q, dcc_q;
  logic                     hit;
  logic [31:0]              hit_tag, hit_data;

  xlat_tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(tlb_we), .widx(tlb_idx), .wsel(tlb_word),
    .wdata(tlb_wdata), .inv_all(tlb_inv_all),
    .tag_q(tag_q), .data_q(data_q), .valid_q(valid_q)
  );

  xlat_match #(.ENTRIES(ENTRIES)) u_match (
    .addr(req_addr), .tag_q(tag_q), .data_q(data_q), .valid_q(valid_q),
    .hit(hit), .hit_tag(hit_tag), .hit_data(hit_data)
  );

  xlat_realmode u_real (
    .clk(clk), .rst_n(rst_n), .rm_we(rm_we), .rm_sel(rm_sel), .rm_wdata(rm_wdata),
    .mode_we(mode_we), .mode_ir(mode_ir), .mode_dr(mode_dr), .exc_take(exc_take),
    .ir_on(ir_on), .dr_on(dr_on), .icc_q(icc_q), .dcc_q(dcc_q)
  );

  // next result, combinational from the request
  acc_kind_e   kind;
  logic        is_fetch, is_store, use_xl, rm_cache, no_perm;
  logic [4:0]  region;
  logic [31:0] pmask;
  xl_rsp_t     nxt, cur;

  always_comb begin
    kind     = acc_kind_e'(req_kind);
    is_fetch = (kind == K_FETCH);
    is_store = (kind == K_STORE);
    use_xl   = is_fetch ? ir_on : dr_on;
    region   = req_addr[31:27];
    rm_cache = is_fetch ? icc_q[~region] : dcc_q[~region];
    pmask    = off_mask(hit_tag[T_SZ_HI:T_SZ_LO]);
    no_perm  = (is_fetch && !hit_data[D_EX]) || (is_store && !hit_data[D_WR]);
    nxt      = '0;
    if (!use_xl) begin
      nxt.pa = req_addr;
      nxt.ci = !rm_cache;
    end else begin
      nxt.xl = 1'b1;
      if (!hit) begin
        nxt.miss = 1'b1;
      end else if (no_perm) begin
        nxt.perm = 1'b1;
      end else begin
        nxt.pa = (hit_data & ~pmask) | (req_addr & pmask);
        nxt.ci = hit_data[D_CI];
        nxt.wt = hit_data[D_WT];
        nxt.gd = hit_data[D_GD];
      end
    end
  end

  // single output stage with valid/ready
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      cur       <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) cur <= nxt;
    end
  end

  assign rsp_paddr      = cur.pa;
  assign rsp_inhibit    = cur.ci;
  assign rsp_wthru      = cur.wt;
  assign rsp_guard      = cur.gd;
  assign rsp_xlated     = cur.xl;
  assign rsp_miss       = cur.miss;
  assign rsp_perm_fault = cur.perm;
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic        rsp_inhibit,
  input logic        rsp_wthru,
  input logic        rsp_guard,
  input logic        rsp_xlated,
  input logic        rsp_miss,
  input logic        rsp_perm_fault,
  input logic        exc_take,
  input logic        ir_on,
  input logic        dr_on
);
  p_exc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (!ir_on && !dr_on));

  p_miss_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_paddr == 32'h0 && !rsp_inhibit && !rsp_wthru && !rsp_guard));

  p_perm_no_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perm_fault) |-> (rsp_paddr == 32'h0 && !rsp_miss));

  p_real_no_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_xlated) |-> (!rsp_miss && !rsp_perm_fault));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_inhibit)
                                   && $stable(rsp_miss) && $stable(rsp_perm_fault)));
endmodule

bind xlat_unit xlat_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_inhibit(rsp_inhibit), .rsp_wthru(rsp_wthru),
  .rsp_guard(rsp_guard), .rsp_xlated(rsp_xlated), .rsp_miss(rsp_miss),
  .rsp_perm_fault(rsp_perm_fault), .exc_take(exc_take), .ir_on(ir_on), .dr_on(dr_on)
);

// File: tb/sim_xlat_unit.sv
module sim_xlat_unit;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, rsp_ready = 1;
  logic [1:0] req_kind = 0;
  logic [31:0] req_addr = 0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_paddr;
  logic rsp_inhibit, rsp_wthru, rsp_guard, rsp_xlated, rsp_miss, rsp_perm_fault;
  logic tlb_we = 0, tlb_word = 0, tlb_inv_all = 0;
  logic [IW-1:0] tlb_idx = 0;
  logic [31:0] tlb_wdata = 0;
  logic rm_we = 0, rm_sel = 0;
  logic [31:0] rm_wdata = 0;
  logic mode_we = 0, mode_ir = 0, mode_dr = 0, exc_take = 0;
  logic ir_on, dr_on;

  xlat_unit #(.ENTRIES(N)) u0 (.*);

  int checks = 0, fails = 0;
  logic [31:0] btag [N];
  logic [31:0] bdata [N];
  logic bir = 0, bdr = 0;
  logic [31:0] bicc = 0, bdcc = 0;

  task automatic chk(string rq, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  // {xl, miss, perm, ci, wt, gd, pa}
  function automatic logic [37:0] model(logic [1:0] k, logic [31:0] a);
    logic fetch, store, c, found, perm;
    int hi, sh;
    logic [31:0] d, m;
    fetch = (k == 2'd0);
    store = (k == 2'd2);
    if (!(fetch ? bir : bdr)) begin
      c = fetch ? bicc[31 - int'(a[31:27])] : bdcc[31 - int'(a[31:27])];
      return {3'b000, ~c, 2'b00, a};
    end
    found = 0; hi = 0; sh = 10;
    for (int i = 0; i < N; i++) begin
      int s;
      s = 10 + 2 * int'(btag[i][9:7]);
      if (!found && btag[i][6] && ((a >> s) == (btag[i] >> s))) begin
        found = 1; hi = i; sh = s;
      end
    end
    if (!found) return {6'b110000, 32'h0};
    d = bdata[hi];
    perm = fetch ? !d[9] : (store ? !d[8] : 1'b0);
    if (perm) return {6'b101000, 32'h0};
    m = (32'h1 << sh) - 32'h1;
    return {3'b100, d[2], d[3], d[0], (d & ~m) | (a & m)};
  endfunction

  task automatic wr_tlb(int idx, logic w, logic [31:0] v);
    @(negedge clk);
    tlb_we = 1; tlb_idx = IW'(idx); tlb_word = w; tlb_wdata = v;
    @(negedge clk);
    tlb_we = 0;
    if (w) bdata[idx] = v; else btag[idx] = v;
  endtask

  task automatic wr_rm(logic sel, logic [31:0] v);
    @(negedge clk);
    rm_we = 1; rm_sel = sel; rm_wdata = v;
    @(negedge clk);
    rm_we = 0;
    if (sel) bdcc = v; else bicc = v;
  endtask

  task automatic wr_mode(logic i, logic d);
    @(negedge clk);
    mode_we = 1; mode_ir = i; mode_dr = d;
    @(negedge clk);
    mode_we = 0;
    bir = i; bdr = d;
  endtask

  task automatic access(logic [1:0] k, logic [31:0] a, string rq);
    logic [37:0] e;
    string t;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    e = model(k, a);
    t = rq;
    if (t == "") t = e[36] ? "R6 miss" : (e[35] ? "R7 perm" : (e[37] ? "R2 R11 hit" : "R3 R4 real"));
    chk({t, " valid"}, 64'(rsp_valid), 64'd1);
    chk(t, 64'({rsp_xlated, rsp_miss, rsp_perm_fault, rsp_inhibit, rsp_wthru, rsp_guard, rsp_paddr}), 64'(e));
  endtask

  logic [31:0] alist [12] = '{32'h0000_0000, 32'h0012_3456, 32'h003F_FFFC, 32'h0040_0000,
                              32'h1000_0400, 32'h1000_07FC, 32'h1000_0800, 32'h0000_4010,
                              32'h80AB_CDEF, 32'h8100_0000, 32'h0FFF_FFFC, 32'h8000_0000};

  task automatic sweep_list();
    for (int i = 0; i < 12; i++)
      for (int k = 0; k < 4; k++) access(2'(k), alist[i], "");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] p0, p1;
    for (int i = 0; i < N; i++) begin btag[i] = 0; bdata[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R10 reset rsp_valid", 64'(rsp_valid), 0);
    chk("R10 reset req_ready", 64'(req_ready), 1);
    chk("R5 reset modes", 64'({ir_on, dr_on}), 0);

    // real mode with cleared region registers: all inhibited
    for (int r = 0; r < 32; r += 7) access(2'd1, (32'(r) << 27) | 32'h1234, "R4 reset regions");

    wr_rm(1'b0, 32'h8000_0001);
    wr_rm(1'b1, 32'h5A5A_5A5A);
    for (int r = 0; r < 32; r++)
      for (int k = 0; k < 3; k++) access(2'(k), (32'(r) << 27) | 32'h0ABC_DEF0 >> 5, "R4 region sweep");

    // table contents
    wr_tlb(0, 0, 32'h0000_0340); wr_tlb(0, 1, 32'h0040_0104);
    wr_tlb(1, 0, 32'h1000_0440); wr_tlb(1, 1, 32'h2000_0309);
    wr_tlb(2, 0, 32'h0000_4140); wr_tlb(2, 1, 32'h3000_0300);
    wr_tlb(3, 0, 32'h8000_03C0); wr_tlb(3, 1, 32'h0100_0202);

    wr_mode(1, 1);
    chk("R5 mode write", 64'({ir_on, dr_on}), 64'd3);
    access(2'd0, 32'h0000_4010, "R7 fetch no-exec lowest wins R8");
    access(2'd1, 32'h0000_4010, "R8 overlap lowest index");
    access(2'd1, 32'h1000_0404, "R11 attrs W G");
    access(2'd2, 32'h80AB_CDEF, "R7 store no-write");
    access(2'd1, 32'h80AB_CDEF, "R2 16MB page");
    sweep_list();

    // fetch in real mode, data translated
    wr_mode(0, 1);
    sweep_list();
    wr_mode(1, 0);
    sweep_list();

    // exception overrides a simultaneous mode write
    wr_mode(1, 1);
    @(negedge clk);
    exc_take = 1; mode_we = 1; mode_ir = 1; mode_dr = 1;
    @(negedge clk);
    exc_take = 0; mode_we = 0; bir = 0; bdr = 0;
    chk("R5 exception clears modes", 64'({ir_on, dr_on}), 0);
    access(2'd1, 32'h80AB_CDEF, "R5 real after exception");
    access(2'd0, 32'h0000_0010, "R5 fetch real after exception");

    // clearing the lower entry exposes the overlapping higher one
    wr_mode(1, 1);
    wr_tlb(0, 0, 32'h0000_0300);
    access(2'd1, 32'h0000_4010, "R8 higher index after clear");
    access(2'd0, 32'h0000_7FF0, "R8 higher index fetch");
    access(2'd1, 32'h0000_0010, "R1 valid bit cleared");

    // stall: result held, no acceptance
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_kind = 2'd1; req_addr = 32'h1000_0410;
    @(negedge clk);
    p0 = model(2'd1, 32'h1000_0410);
    req_addr = 32'h8000_1000;
    p1 = model(2'd1, 32'h8000_1000);
    for (int c = 0; c < 3; c++) begin
      chk("R10 stall req_ready low", 64'(req_ready), 0);
      chk("R10 stall result held", 64'({rsp_valid, rsp_paddr}), {31'd0, 1'b1, p0});
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 next after drain", 64'({rsp_valid, rsp_paddr}), {31'd0, 1'b1, p1});
    @(negedge clk);
    chk("R10 empty after drain", 64'(rsp_valid), 0);

    // invalidate with a simultaneous tag write
    @(negedge clk);
    tlb_inv_all = 1; tlb_we = 1; tlb_idx = 2'd3; tlb_word = 0; tlb_wdata = 32'h8000_03C0;
    @(negedge clk);
    tlb_inv_all = 0; tlb_we = 0;
    for (int i = 0; i < N; i++) btag[i][6] = 1'b0;
    access(2'd1, 32'h80AB_CDEF, "R9 invalidate beats write");
    access(2'd1, 32'h1000_0404, "R9 all invalid");
    sweep_list();
    finish_run();
  end
endmodule